// File: doc/BRIEF.md
# Host Bus Window Address Translator

This block claims host bus accesses that land in a fixed 1 GB address window. For each claimed access it builds one outbound request for a PCI-style master port. Bits 29:0 of the outbound address come from the host address. The top two bits come from a field in a control register. A control bit decides whether every access in the window goes out as a memory cycle or as a configuration cycle. The request leaves through a valid/ready handshake. It carries the address, write data, byte enables, direction and the cycle-type flag. The block holds one request at a time.

The same control register also sets:
- the drive of the downstream bus reset pin (released, driven low or driven high);
- the grant policy passed to the arbiter;
- a cache-disable flag for external accesses;
- a transmit-enable flag for fragments.

A second register holds the number of host clock cycles in one millisecond. A counter uses it to produce a periodic one-cycle tick. Both registers are on a plain 32-bit register port. A read returns its data one cycle after the request.

The forwarding control is a two-state machine:
- **FWD_IDLE**: waiting for a host access.
- **FWD_ISSUE**: offering the captured request downstream.

Its transitions:
- **T_ACCEPT**: FWD_IDLE to FWD_ISSUE, taken when a valid host access hits the window.
- **T_DONE**: FWD_ISSUE back to FWD_IDLE, taken when the downstream side raises ready.
- **T_WAIT**: stays in FWD_ISSUE while ready is low.
- **T_IDLE**: stays in FWD_IDLE when there is no valid access, or when the access misses the window.

Top module: `hbw_xlate`

## Requirements
- R1: A host access is accepted (hst_ready high) only when hst_addr lies in 0x80000000..0xBFFFFFFF, that is when address bits 31:30 equal 2'b10. Outside that range hst_ready stays low and hst_miss is high while hst_valid is high.
- R2: The outbound address is {misc[3:2], hst_addr[29:0]}, captured in the cycle the access is accepted.
- R3: dn_cfg equals misc bit 1 at acceptance: 1 gives a configuration cycle, 0 gives a memory cycle. dn_we, dn_wdata and dn_be repeat the accepted host values.
- R4: After acceptance, dn_valid is high from the next cycle and stays high with a stable payload until dn_ready is seen. While dn_valid is high, hst_ready is low.
- R5: misc bits 5:4 set the reset pin drive. Value 0 releases it (bus_rst_oe=0). Value 1 drives it low (oe=1, level=0). Value 2 drives it high (oe=1, level=1). Value 3 releases it.
- R6: grant_mode outputs misc bits 7:6 (0 early, 1 wait for frame, 2 wait for idle). cache_dis outputs misc bit 12. frag_tx_en outputs misc bit 0.
- R7: The misc register is at offset 0x0C, with writable bits 12 and 7:0. The millisecond count is at offset 0x08, 18 bits wide. Reserved bits and unmapped offsets read as zero. Read data appears in the cycle after the read request.
- R8: With a millisecond count N > 0, ms_tick is a one-cycle pulse every N cycles. N = 1 gives a tick on every cycle.
- R9: A millisecond count of zero stops ms_tick.
- R10: After reset, both registers read zero, dn_valid is low and the reset pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | Register write (1) or read (0) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after request |
| hst_valid | input | 1 | Host access present |
| hst_ready | output | 1 | Host access accepted this cycle |
| hst_miss | output | 1 | Host access lies outside the window |
| hst_addr | input | 32 | Host address |
| hst_we | input | 1 | Host write |
| hst_wdata | input | 32 | Host write data |
| hst_be | input | 4 | Host byte enables |
| dn_valid | output | 1 | Outbound request valid |
| dn_ready | input | 1 | Outbound request taken |
| dn_addr | output | 32 | Outbound bus address |
| dn_we | output | 1 | Outbound write |
| dn_wdata | output | 32 | Outbound write data |
| dn_be | output | 4 | Outbound byte enables |
| dn_cfg | output | 1 | Configuration cycle (1) or memory cycle (0) |
| bus_rst_oe | output | 1 | Reset pin driver enable |
| bus_rst_level | output | 1 | Reset pin drive level |
| grant_mode | output | 2 | Grant policy select |
| cache_dis | output | 1 | External access cache disable |
| frag_tx_en | output | 1 | Fragment transmit enable |
| ms_tick | output | 1 | Millisecond tick pulse |

## Verification
The hardest case to reach is a host access that arrives while an earlier request is still stalled downstream. A host access in this state must be refused, and the pending payload must not change. The stimulus gets there by holding dn_ready low for several cycles after an accepted access. During the stall it presents a second in-window access with different data. The window edges 0x7FFFFFFF, 0x80000000, 0xBFFFFFFF and 0xC0000000 are exercised directly. The upper-bit field and the cycle-type bit are reprogrammed between accesses, so that the request shows the register value from the moment of acceptance.

// File: rtl/hbw_pkg.sv
package hbw_pkg;
    localparam int DATA_W    = 32;
    localparam int REG_AW    = 8;
    localparam int MS_W      = 18;
    localparam int BE_W      = DATA_W / 8;

    localparam logic [REG_AW-1:0] OFS_MS_LIMIT = 8'h08;
    localparam logic [REG_AW-1:0] OFS_MISC     = 8'h0C;

    // writable bits of the misc register
    localparam logic [DATA_W-1:0] MISC_WMASK = 32'h0000_10FF;

    // window select: host address bits 31:30 must equal this
    localparam logic [1:0] WIN_TAG = 2'b10;

    typedef enum logic [1:0] {
        RSTM_RELEASE = 2'd0,
        RSTM_LOW     = 2'd1,
        RSTM_HIGH    = 2'd2,
        RSTM_RSVD    = 2'd3
    } rst_mode_t;

    typedef struct packed {
        logic      cache_dis;
        logic [1:0] grant;
        rst_mode_t rst_mode;
        logic [1:0] hi_bits;
        logic      cfg_sel;
        logic      frag_tx;
    } misc_t;

    typedef enum logic {
        FWD_IDLE  = 1'b0,
        FWD_ISSUE = 1'b1
    } fwd_state_t;
endpackage

// File: rtl/hbw_regs.sv
module hbw_regs
    import hbw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output misc_t             misc,
    output logic [MS_W-1:0]   ms_limit
);
    logic [DATA_W-1:0] misc_word;
    logic [DATA_W-1:0] rd_mux;

    assign misc_word = {19'd0, misc.cache_dis, 4'd0, misc.grant,
                        misc.rst_mode, misc.hi_bits, misc.cfg_sel, misc.frag_tx};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            misc     <= '0;
            ms_limit <= '0;
        end else if (reg_en && reg_we) begin
            if (reg_addr == OFS_MISC) begin
                misc.frag_tx   <= reg_wdata[0];
                misc.cfg_sel   <= reg_wdata[1];
                misc.hi_bits   <= reg_wdata[3:2];
                misc.rst_mode  <= rst_mode_t'(reg_wdata[5:4]);
                misc.grant     <= reg_wdata[7:6];
                misc.cache_dis <= reg_wdata[12];
            end
            if (reg_addr == OFS_MS_LIMIT) begin
                ms_limit <= reg_wdata[MS_W-1:0];
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        if (reg_addr == OFS_MISC) begin
            rd_mux = misc_word & MISC_WMASK;
        end else if (reg_addr == OFS_MS_LIMIT) begin
            rd_mux = {{(DATA_W-MS_W){1'b0}}, ms_limit};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else begin
            reg_rdata <= (reg_en && !reg_we) ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/hbw_tick.sv
module hbw_tick #(
    parameter int CW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] limit,
    output logic          tick
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last = limit - CW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (limit == '0) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= last) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + CW'(1);
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/hbw_fwd.sv
module hbw_fwd
    import hbw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  misc_t             misc,
    input  logic              hst_valid,
    output logic              hst_ready,
    output logic              hst_miss,
    input  logic [DATA_W-1:0] hst_addr,
    input  logic              hst_we,
    input  logic [DATA_W-1:0] hst_wdata,
    input  logic [BE_W-1:0]   hst_be,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [DATA_W-1:0] dn_addr,
    output logic              dn_we,
    output logic [DATA_W-1:0] dn_wdata,
    output logic [BE_W-1:0]   dn_be,
    output logic              dn_cfg
);
    fwd_state_t state, nxt;
    logic       in_win;
    logic       take;

    assign in_win = (hst_addr[DATA_W-1:DATA_W-2] == WIN_TAG);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= FWD_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            FWD_IDLE:  if (hst_valid && in_win) nxt = FWD_ISSUE;
            FWD_ISSUE: if (dn_ready)            nxt = FWD_IDLE;
            default:                            nxt = FWD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        hst_ready = 1'b0;
        dn_valid  = 1'b0;
        unique case (state)
            FWD_IDLE:  hst_ready = in_win;
            FWD_ISSUE: dn_valid  = 1'b1;
            default: ;
        endcase
    end

    assign hst_miss = hst_valid && !in_win;
    assign take     = hst_valid && hst_ready;

    // payload capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_addr  <= '0;
            dn_we    <= 1'b0;
            dn_wdata <= '0;
            dn_be    <= '0;
            dn_cfg   <= 1'b0;
        end else if (take) begin
            dn_addr  <= {misc.hi_bits, hst_addr[DATA_W-3:0]};
            dn_we    <= hst_we;
            dn_wdata <= hst_wdata;
            dn_be    <= hst_be;
            dn_cfg   <= misc.cfg_sel;
        end
    end
endmodule

// File: rtl/hbw_xlate.sv
module hbw_xlate
    import hbw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              hst_valid,
    output logic              hst_ready,
    output logic              hst_miss,
    input  logic [DATA_W-1:0] hst_addr,
    input  logic              hst_we,
    input  logic [DATA_W-1:0] hst_wdata,
    input  logic [BE_W-1:0]   hst_be,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [DATA_W-1:0] dn_addr,
    output logic              dn_we,
    output logic [DATA_W-1:0] dn_wdata,
    output logic [BE_W-1:0]   dn_be,
    output logic              dn_cfg,
    output logic              bus_rst_oe,
    output logic              bus_rst_level,
    output logic [1:0]        grant_mode,
    output logic              cache_dis,
    output logic              frag_tx_en,
    output logic              ms_tick
);
    misc_t           misc_q;
    logic [MS_W-1:0] ms_limit;

    hbw_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .misc(misc_q), .ms_limit(ms_limit)
    );

    hbw_tick #(.CW(MS_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .limit(ms_limit), .tick(ms_tick)
    );

    hbw_fwd u_fwd (
        .clk(clk), .rst_n(rst_n), .misc(misc_q),
        .hst_valid(hst_valid), .hst_ready(hst_ready), .hst_miss(hst_miss),
        .hst_addr(hst_addr), .hst_we(hst_we), .hst_wdata(hst_wdata),
        .hst_be(hst_be), .dn_valid(dn_valid), .dn_ready(dn_ready),
        .dn_addr(dn_addr), .dn_we(dn_we), .dn_wdata(dn_wdata),
        .dn_be(dn_be), .dn_cfg(dn_cfg)
    );

    always_comb begin
        bus_rst_oe    = 1'b0;
        bus_rst_level = 1'b0;
        unique case (misc_q.rst_mode)
            RSTM_LOW:  bus_rst_oe = 1'b1;
            RSTM_HIGH: begin bus_rst_oe = 1'b1; bus_rst_level = 1'b1; end
            default: ;
        endcase
    end

    assign grant_mode = misc_q.grant;
    assign cache_dis  = misc_q.cache_dis;
    assign frag_tx_en = misc_q.frag_tx;
endmodule

// File: rtl/hbw_xlate_chk.sv
module hbw_xlate_chk
    import hbw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input misc_t             misc_q,
    input logic [MS_W-1:0]   ms_limit,
    input logic              hst_valid,
    input logic              hst_ready,
    input logic [DATA_W-1:0] hst_addr,
    input logic              dn_valid,
    input logic              dn_ready,
    input logic [DATA_W-1:0] dn_addr,
    input logic [DATA_W-1:0] dn_wdata,
    input logic              dn_cfg,
    input logic              bus_rst_oe,
    input logic              bus_rst_level,
    input logic              ms_tick
);
    a_r1_no_claim_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_valid && hst_addr[31:30] != WIN_TAG) |-> !hst_ready);

    a_r2_addr_formed: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_valid && hst_ready) |=>
        (dn_addr == {$past(misc_q.hi_bits), $past(hst_addr[29:0])}));

    a_r3_cycle_type: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_valid && hst_ready) |=> (dn_cfg == $past(misc_q.cfg_sel)));

    a_r4_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=>
        (dn_valid && $stable(dn_addr) && $stable(dn_wdata) && $stable(dn_cfg)));

    a_r4_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> !hst_ready);

    a_r5_drive_low: assert property (@(posedge clk) disable iff (!rst_n)
        (misc_q.rst_mode == RSTM_LOW) |-> (bus_rst_oe && !bus_rst_level));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_tick && ms_limit > 1) |=> (!ms_tick || ms_limit != $past(ms_limit)));

    a_r9_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_limit == '0) |=> !ms_tick);
endmodule

bind hbw_xlate hbw_xlate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .misc_q(misc_q), .ms_limit(ms_limit),
    .hst_valid(hst_valid), .hst_ready(hst_ready), .hst_addr(hst_addr),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr),
    .dn_wdata(dn_wdata), .dn_cfg(dn_cfg), .bus_rst_oe(bus_rst_oe),
    .bus_rst_level(bus_rst_level), .ms_tick(ms_tick)
);

// File: tb/hbw_xlate_tb.sv
module hbw_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        hst_valid = 1'b0, hst_ready, hst_miss, hst_we = 1'b0;
    logic [31:0] hst_addr = '0, hst_wdata = '0;
    logic [3:0]  hst_be = '0;
    logic        dn_valid, dn_ready = 1'b0, dn_we, dn_cfg;
    logic [31:0] dn_addr, dn_wdata;
    logic [3:0]  dn_be;
    logic        bus_rst_oe, bus_rst_level, cache_dis, frag_tx_en, ms_tick;
    logic [1:0]  grant_mode;
    int n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    hbw_xlate u_dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_en = 0; reg_we = 0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_en = 1; reg_we = 0; reg_addr = a;
        @(negedge clk); d = reg_rdata; reg_en = 0;
    endtask

    // present one access; expect acceptance or rejection
    task automatic host_try(input logic [31:0] a, input logic [31:0] d,
                            input bit exp_acc, input string req);
        @(negedge clk);
        hst_valid = 1; hst_addr = a; hst_wdata = d; hst_we = 1; hst_be = 4'hA;
        #1;
        chk(hst_ready == exp_acc, req, "hst_ready", {31'd0, hst_ready}, {31'd0, exp_acc});
        chk(hst_miss == !exp_acc, req, "hst_miss", {31'd0, hst_miss}, {31'd0, !exp_acc});
        @(negedge clk); hst_valid = 0;
        chk(dn_valid == exp_acc, req, "dn_valid after try", {31'd0, dn_valid}, {31'd0, exp_acc});
    endtask

    task automatic drain();
        @(negedge clk); dn_ready = 1;
        @(negedge clk); dn_ready = 0;
        chk(!dn_valid, "R4", "dn_valid after ready", {31'd0, dn_valid}, 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] r;
        chk(!dn_valid && !bus_rst_oe && !ms_tick, "R10", "outputs after reset",
            {29'd0, dn_valid, bus_rst_oe, ms_tick}, 32'd0);
        reg_read(8'h0C, r); chk(r == 0, "R10", "misc reset", r, 0);
        reg_read(8'h08, r); chk(r == 0, "R10", "count reset", r, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] r;
        reg_write(8'h0C, 32'hFFFF_FFFF);
        reg_read(8'h0C, r); chk(r == 32'h0000_10FF, "R7", "misc mask", r, 32'h10FF);
        reg_write(8'h08, 32'hFFFF_FFFF);
        reg_read(8'h08, r); chk(r == 32'h0003_FFFF, "R7", "count width", r, 32'h3FFFF);
        reg_write(8'h10, 32'h1234_5678);
        reg_read(8'h10, r); chk(r == 0, "R7", "unmapped offset", r, 0);
        reg_write(8'h08, 0);
    endtask

    task automatic t_misc_fields();
        // rst mode bits 5:4, grant 7:6, cache 12, frag 0
        reg_write(8'h0C, 32'h0000_1041); // frag=1, grant=1, cache=1, rst=0
        chk(frag_tx_en && cache_dis && grant_mode == 2'd1, "R6", "fields a",
            {29'd0, frag_tx_en, grant_mode}, 32'h5);
        chk(!bus_rst_oe, "R5", "mode 0 release", {31'd0, bus_rst_oe}, 0);
        reg_write(8'h0C, 32'h0000_0090); // grant=2, rst=1
        chk(!frag_tx_en && !cache_dis && grant_mode == 2'd2, "R6", "fields b",
            {29'd0, frag_tx_en, grant_mode}, 32'h2);
        chk(bus_rst_oe && !bus_rst_level, "R5", "mode 1 low",
            {30'd0, bus_rst_oe, bus_rst_level}, 32'h2);
        reg_write(8'h0C, 32'h0000_0020);
        chk(bus_rst_oe && bus_rst_level, "R5", "mode 2 high",
            {30'd0, bus_rst_oe, bus_rst_level}, 32'h3);
        reg_write(8'h0C, 32'h0000_0030);
        chk(!bus_rst_oe, "R5", "mode 3 release", {31'd0, bus_rst_oe}, 0);
    endtask

    task automatic t_window();
        host_try(32'h7FFF_FFFF, 32'h1, 1'b0, "R1");
        host_try(32'hC000_0000, 32'h2, 1'b0, "R1");
        host_try(32'h4000_0010, 32'h3, 1'b0, "R1");
        host_try(32'h8000_0000, 32'h4, 1'b1, "R1");
        drain();
        host_try(32'hBFFF_FFFC, 32'h5, 1'b1, "R1");
        drain();
    endtask

    task automatic t_translate();
        reg_write(8'h0C, 32'h0000_0004); // hi_bits=1, memory cycle
        host_try(32'h8123_4560, 32'hCAFE_0001, 1'b1, "R2");
        chk(dn_addr == 32'h4123_4560, "R2", "addr hi=1", dn_addr, 32'h4123_4560);
        chk(!dn_cfg && dn_we && dn_wdata == 32'hCAFE_0001 && dn_be == 4'hA, "R3",
            "mem payload", dn_wdata, 32'hCAFE_0001);
        drain();
        reg_write(8'h0C, 32'h0000_000E); // hi_bits=3, config cycle
        host_try(32'hA000_0800, 32'hBEEF_0002, 1'b1, "R2");
        chk(dn_addr == 32'hE000_0800, "R2", "addr hi=3", dn_addr, 32'hE000_0800);
        chk(dn_cfg, "R3", "config cycle", {31'd0, dn_cfg}, 1);
        // change register while pending: captured value holds
        reg_write(8'h0C, 32'h0000_0000);
        chk(dn_cfg && dn_addr == 32'hE000_0800, "R3", "captured at accept", dn_addr, 32'hE000_0800);
        drain();
    endtask

    task automatic t_stall();
        host_try(32'h9000_0100, 32'h1111_1111, 1'b1, "R4");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            hst_valid = 1; hst_addr = 32'h8000_0200; hst_wdata = 32'h2222_2222;
            #1;
            chk(!hst_ready, "R4", "refuse while busy", {31'd0, hst_ready}, 0);
            chk(dn_valid && dn_addr == 32'h1000_0100 && dn_wdata == 32'h1111_1111,
                "R4", "payload held", dn_wdata, 32'h1111_1111);
        end
        hst_valid = 0;
        drain();
    endtask

    task automatic count_ticks(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk); if (ms_tick) n++;
        end
    endtask

    task automatic t_tick();
        int n, gap;
        reg_write(8'h08, 5);
        gap = 0;
        while (!ms_tick && gap < 20) begin @(negedge clk); gap++; end
        count_ticks(50, n); chk(n == 10, "R8", "ticks N=5 in 50", n, 10);
        gap = 0;
        @(negedge clk);
        while (!ms_tick && gap < 20) begin @(negedge clk); gap++; end
        chk(gap == 4, "R8", "cycles between ticks minus one", gap, 4);
        reg_write(8'h08, 1);
        @(negedge clk);
        count_ticks(20, n); chk(n == 20, "R8", "ticks N=1", n, 20);
        reg_write(8'h08, 0);
        @(negedge clk);
        count_ticks(30, n); chk(n == 0, "R9", "ticks N=0", n, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_regmap();
        t_misc_fields();
        reg_write(8'h0C, 0);
        t_window();
        t_translate();
        t_stall();
        t_tick();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule